// File: doc/BRIEF.md
# Serial 14-bit Converter Host Controller

This block is the host-side master for a successive-approximation converter that is driven over a four-wire serial link. A client hands it one conversion request carrying a channel number, a bipolar/unipolar choice, a single-ended/differential choice and the converter's clocking mode. The controller then lowers chip select and sends the converter's 8-bit command. It reads back the 14-bit sample and returns it on a valid/ready result port, zero-extended for unipolar requests and sign-extended for bipolar ones.

The serial clock idles low. The host changes its data line after each falling edge and samples the converter's data line at each rising edge. The clock's half period is a whole number of system clocks, set by a parameter. When the converter runs the conversion from the serial clock, the read clocks follow the command directly. When the converter uses its own clock, the host parks the serial clock low, with chip select still low, until it sees a rising edge on the converter's ready strobe. A watchdog limits that wait. On expiry the host abandons the conversion, raises an error flag, and flushes the converter's input with zeros at the start of the next transaction.

Top module: `sar_link_host`

## Requirements
- R1: While `csN` is high, `sclk` is low. `mosi` never changes while `sclk` is high, so it changes only at falling edges or while the clock is parked low. Every high phase of `sclk` lasts exactly HALF_DIV system clocks.
- R2: The command byte goes out MSB first after `csN` falls. Its bits, from first to last, are: a 1 (start), channel bits 2, 1 and 0, a unipolar flag (1 when `reqBipolar` is 0), a single-ended flag (equal to `reqSingleEnded`), and a two-bit mode field. The mode field is 11 for a serial-clocked conversion and 10 for a self-clocked one (`reqIntClock` = 1).
- R3: In serial-clocked mode, 16 read clocks follow the command without a pause, giving 24 rising edges per chip-select window. Sample bits D13..D0 are taken at read clocks 1 to 14, and read clocks 15 and 16 are ignored.
- R4: In self-clocked mode, after the command the host keeps `sclk` low and `csN` low until the strobe shows a rising edge. It then gives 16 read clocks. Read clocks 1 and 2 are ignored and D13..D0 are taken at read clocks 3 to 16, giving 24 rising edges per window.
- R5: For a unipolar request, `resData` holds the 14 sample bits in its low bits and zeros above them.
- R6: For a bipolar request, `resData` holds the sample as a two's-complement value sign-extended from bit 13.
- R7: `reqReady` is high only when the block is idle. Once `resValid` rises, it stays high with `resData` unchanged until `resReady` is seen, and no new request is accepted meanwhile.
- R8: In self-clocked mode, if no strobe rising edge arrives within TIMEOUT_CYC system clocks after the command, `csN` rises and `convTimeout` goes high. No result is returned. `convTimeout` clears when the next request is accepted.
- R9: The transaction after a timeout clocks exactly 18 zero bits in the same chip-select window before the start bit. Later transactions send none.
- R10: During and right after reset, `csN` is high, `sclk`, `mosi`, `resValid` and `convTimeout` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Conversion request present |
| reqReady | output | 1 | Block idle, request accepted this cycle if valid |
| reqChannel | input | 3 | Channel number placed in the command |
| reqBipolar | input | 1 | 1 = two's-complement result |
| reqSingleEnded | input | 1 | 1 = single-ended input, 0 = differential pair |
| reqIntClock | input | 1 | 1 = converter uses its own clock and strobe |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Client takes the result |
| resData | output | OUT_W (16) | Extended conversion result |
| convTimeout | output | 1 | Strobe wait expired on the last request |
| sclk | output | 1 | Serial clock to the converter |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| sstrb | input | 1 | Converter's end-of-conversion strobe |

## Verification
If the read-bit counter or the mode flag is wrong, the frame position slips: the result comes back shifted by up to two places or has lost its top bits. This shows on the first completed transaction. If the bit counter is wrong, the number of rising edges in the window differs from 24 (or from 42 after a flush), which a converter model on the pins sees at once. Broken strobe-wait logic either clocks during the conversion or never leaves the wait. The first makes the converter model report a protocol error on that transaction. The second raises `convTimeout` about TIMEOUT_CYC cycles later instead of returning a result. A lost flush marker shows only on the transaction after a timeout, as a missing or repeated run of 18 zeros.

// File: rtl/sar_link_pkg.sv
`timescale 1ns/1ps
package sar_link_pkg;

  // Command byte layout and fixed framing of the converter link.
  localparam int CMD_BITS   = 8;
  localparam int CH_W       = 3;
  localparam int FLUSH_BITS = 18;
  localparam int FRAME_BITS = 2;
  localparam logic [1:0] MODE_EXT = 2'b11;
  localparam logic [1:0] MODE_INT = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_CMD,
    ST_WAIT,
    ST_READ,
    ST_DONE
  } linkState_t;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadCmd;
    logic shiftTx;
    logic muteTx;
    logic capture;
    logic publish;
  } dpCtl_t;

endpackage

// File: rtl/sar_link_sync.sv
`timescale 1ns/1ps
module sar_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : gStage
      if (i == 0) begin : gFirst
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= din;
        end
      end else begin : gNext
        always_ff @(posedge clk) begin
          if (!rstN) chain[i] <= 1'b0;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/sar_link_dp.sv
`timescale 1ns/1ps
module sar_link_dp
  import sar_link_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic [CH_W-1:0]   reqChannel,
  input  logic              reqBipolar,
  input  logic              reqSingleEnded,
  input  logic              reqIntClock,
  input  logic              miso,
  input  logic              sstrb,
  output logic              mosi,
  output logic              strobeRise,
  output logic [OUT_W-1:0]  resData
);

  logic [CMD_BITS-1:0] txReg;
  logic [CMD_BITS-1:0] cmdByte;
  logic [DATA_W-1:0]   rxReg;
  logic [OUT_W-1:0]    resReg;
  logic [OUT_W-1:0]    extended;
  logic                bipReg;
  logic                strobeSync;
  logic                strobePrev;

  always_comb begin
    cmdByte = {1'b1, reqChannel, ~reqBipolar, reqSingleEnded,
               reqIntClock ? MODE_INT : MODE_EXT};
  end

  generate
    if (OUT_W > DATA_W) begin : gExtend
      always_comb begin
        extended = {{(OUT_W-DATA_W){bipReg & rxReg[DATA_W-1]}}, rxReg};
      end
    end else begin : gNoExtend
      always_comb begin
        extended = rxReg[DATA_W-1 -: OUT_W];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg  <= '0;
      rxReg  <= '0;
      resReg <= '0;
      bipReg <= 1'b0;
    end else begin
      if (dpCtl.loadCmd) begin
        txReg  <= cmdByte;
        rxReg  <= '0;
        bipReg <= reqBipolar;
      end else if (dpCtl.shiftTx) begin
        txReg <= {txReg[CMD_BITS-2:0], 1'b0};
      end
      if (dpCtl.capture) rxReg <= {rxReg[DATA_W-2:0], miso};
      if (dpCtl.publish) resReg <= extended;
    end
  end

  sar_link_sync #(.STAGES(SYNC_STAGES)) i_strobeSync (
    .clk  (clk),
    .rstN (rstN),
    .din  (sstrb),
    .dout (strobeSync)
  );

  always_ff @(posedge clk) begin
    if (!rstN) strobePrev <= 1'b0;
    else       strobePrev <= strobeSync;
  end

  assign strobeRise = strobeSync & ~strobePrev;
  assign mosi       = dpCtl.muteTx ? 1'b0 : txReg[CMD_BITS-1];
  assign resData    = resReg;

endmodule

// File: rtl/sar_link_ctrl.sv
`timescale 1ns/1ps
module sar_link_ctrl
  import sar_link_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   reqIntClock,
  input  logic   resReady,
  input  logic   strobeRise,
  output logic   reqReady,
  output logic   resValid,
  output logic   csN,
  output logic   sclk,
  output logic   convTimeout,
  output dpCtl_t dpCtl
);

  localparam int READ_BITS = DATA_W + FRAME_BITS;
  localparam int MAX_BITS  = (FLUSH_BITS > READ_BITS) ? FLUSH_BITS : READ_BITS;
  localparam int IDX_W     = $clog2(MAX_BITS);
  localparam int HALF_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int TMO_W     = $clog2(TIMEOUT_CYC + 1);

  linkState_t        state;
  logic [HALF_W-1:0] halfCnt;
  logic              highPhase;
  logic [IDX_W-1:0]  bitIdx;
  logic [IDX_W-1:0]  lastIdx;
  logic [TMO_W-1:0]  waitCnt;
  logic              intMode;
  logic              needFlush;
  logic              csNReg;
  logic              sclkReg;
  logic              errReg;

  logic accept, shifting, tick, edgeRise, edgeFall, lastBit, dataBit;

  always_comb begin
    unique case (state)
      ST_FLUSH: lastIdx = IDX_W'(FLUSH_BITS - 1);
      ST_CMD:   lastIdx = IDX_W'(CMD_BITS - 1);
      default:  lastIdx = IDX_W'(READ_BITS - 1);
    endcase
  end

  always_comb begin
    accept   = (state == ST_IDLE) && reqValid;
    shifting = (state == ST_FLUSH) || (state == ST_CMD) || (state == ST_READ);
    tick     = (halfCnt == HALF_W'(HALF_DIV - 1));
    edgeRise = shifting && tick && !highPhase;
    edgeFall = shifting && tick && highPhase;
    lastBit  = (bitIdx == lastIdx);
    dataBit  = intMode ? (bitIdx >= IDX_W'(FRAME_BITS))
                       : (bitIdx <  IDX_W'(DATA_W));
  end

  always_comb begin
    dpCtl.loadCmd = accept;
    dpCtl.shiftTx = edgeFall && (state == ST_CMD);
    dpCtl.muteTx  = (state != ST_CMD);
    dpCtl.capture = edgeRise && (state == ST_READ) && dataBit;
    dpCtl.publish = edgeFall && (state == ST_READ) && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      highPhase <= 1'b0;
      bitIdx    <= '0;
      waitCnt   <= '0;
      intMode   <= 1'b0;
      needFlush <= 1'b0;
      csNReg    <= 1'b1;
      sclkReg   <= 1'b0;
      errReg    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            csNReg    <= 1'b0;
            intMode   <= reqIntClock;
            errReg    <= 1'b0;
            needFlush <= 1'b0;
            halfCnt   <= '0;
            highPhase <= 1'b0;
            bitIdx    <= '0;
            state     <= needFlush ? ST_FLUSH : ST_CMD;
          end
        end
        ST_FLUSH, ST_CMD, ST_READ: begin
          if (tick) begin
            halfCnt   <= '0;
            highPhase <= ~highPhase;
            sclkReg   <= ~highPhase;
            if (highPhase) begin
              if (lastBit) begin
                bitIdx <= '0;
                if (state == ST_FLUSH) begin
                  state <= ST_CMD;
                end else if (state == ST_CMD) begin
                  waitCnt <= '0;
                  state   <= intMode ? ST_WAIT : ST_READ;
                end else begin
                  csNReg <= 1'b1;
                  state  <= ST_DONE;
                end
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (strobeRise) begin
            halfCnt   <= '0;
            highPhase <= 1'b0;
            state     <= ST_READ;
          end else if (waitCnt == TMO_W'(TIMEOUT_CYC - 1)) begin
            csNReg    <= 1'b1;
            errReg    <= 1'b1;
            needFlush <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DONE: begin
          if (resReady) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady    = (state == ST_IDLE);
  assign resValid    = (state == ST_DONE);
  assign csN         = csNReg;
  assign sclk        = sclkReg;
  assign convTimeout = errReg;

endmodule

// File: rtl/sar_link_host.sv
`timescale 1ns/1ps
module sar_link_host
  import sar_link_pkg::*;
#(
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 16,
  parameter int HALF_DIV    = 4,
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [2:0]       reqChannel,
  input  logic             reqBipolar,
  input  logic             reqSingleEnded,
  input  logic             reqIntClock,
  output logic             resValid,
  input  logic             resReady,
  output logic [OUT_W-1:0] resData,
  output logic             convTimeout,
  output logic             sclk,
  output logic             csN,
  output logic             mosi,
  input  logic             miso,
  input  logic             sstrb
);

  dpCtl_t dpCtl;
  logic   strobeRise;

  sar_link_ctrl #(
    .DATA_W      (DATA_W),
    .HALF_DIV    (HALF_DIV),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqIntClock (reqIntClock),
    .resReady    (resReady),
    .strobeRise  (strobeRise),
    .reqReady    (reqReady),
    .resValid    (resValid),
    .csN         (csN),
    .sclk        (sclk),
    .convTimeout (convTimeout),
    .dpCtl       (dpCtl)
  );

  sar_link_dp #(
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W)
  ) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .dpCtl          (dpCtl),
    .reqChannel     (reqChannel),
    .reqBipolar     (reqBipolar),
    .reqSingleEnded (reqSingleEnded),
    .reqIntClock    (reqIntClock),
    .miso           (miso),
    .sstrb          (sstrb),
    .mosi           (mosi),
    .strobeRise     (strobeRise),
    .resData        (resData)
  );

endmodule

// File: rtl/sar_link_chk.sv
`timescale 1ns/1ps
module sar_link_chk #(
  parameter int DATA_W   = 14,
  parameter int OUT_W    = 16,
  parameter int HALF_DIV = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqBipolar,
  input logic             resValid,
  input logic             resReady,
  input logic [OUT_W-1:0] resData,
  input logic             convTimeout,
  input logic             sclk,
  input logic             csN,
  input logic             mosi
);

  localparam int HI_W = $clog2(HALF_DIV + 2);

  logic [HI_W-1:0] hiLen;
  logic            bipSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiLen   <= '0;
      bipSeen <= 1'b0;
    end else begin
      hiLen <= sclk ? hiLen + 1'b1 : '0;
      if (reqValid && reqReady) bipSeen <= reqBipolar;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R1

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> $stable(mosi)); // R1

  AST_HIGH_PHASE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> (hiLen == HI_W'(HALF_DIV))); // R1

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> (resValid && $stable(resData))); // R7

  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !reqReady); // R7

  AST_TIMEOUT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    convTimeout |-> (csN && !resValid)); // R8

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !convTimeout); // R8

  generate
    if (OUT_W > DATA_W) begin : gExtChk
      AST_UNIPOLAR_ZERO_TOP: assert property (@(posedge clk) disable iff (!rstN)
        (resValid && !bipSeen) |-> (resData[OUT_W-1:DATA_W] == '0)); // R5

      AST_BIPOLAR_SIGN_TOP: assert property (@(posedge clk) disable iff (!rstN)
        (resValid && bipSeen) |->
          (($countones(resData[OUT_W-1:DATA_W-1]) == 0) ||
           ($countones(resData[OUT_W-1:DATA_W-1]) == OUT_W-DATA_W+1))); // R6
    end
  endgenerate

endmodule

bind sar_link_host sar_link_chk #(
  .DATA_W   (DATA_W),
  .OUT_W    (OUT_W),
  .HALF_DIV (HALF_DIV)
) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqReady    (reqReady),
  .reqBipolar  (reqBipolar),
  .resValid    (resValid),
  .resReady    (resReady),
  .resData     (resData),
  .convTimeout (convTimeout),
  .sclk        (sclk),
  .csN         (csN),
  .mosi        (mosi)
);

// File: tb/test_sar_link_host.sv
`timescale 1ns/1ps
module test_sar_link_host;

  localparam int HALF = 4;
  localparam int DW   = 14;
  localparam int OW   = 16;
  localparam int TMO  = 1024;
  localparam int CONV = 60;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic          reqValid = 1'b0;
  logic          reqReady;
  logic [2:0]    reqChannel = '0;
  logic          reqBipolar = 1'b0;
  logic          reqSingleEnded = 1'b0;
  logic          reqIntClock = 1'b0;
  logic          resValid;
  logic          resReady = 1'b0;
  logic [OW-1:0] resData;
  logic          convTimeout;
  logic          sclk, csN, mosi;
  logic          mdlDout;
  logic          mdlStrobe;

  sar_link_host #(.DATA_W(DW), .OUT_W(OW), .HALF_DIV(HALF), .TIMEOUT_CYC(TMO)) i_sar_link_host (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqChannel(reqChannel), .reqBipolar(reqBipolar), .reqSingleEnded(reqSingleEnded),
    .reqIntClock(reqIntClock), .resValid(resValid), .resReady(resReady), .resData(resData),
    .convTimeout(convTimeout), .sclk(sclk), .csN(csN), .mosi(mosi),
    .miso(mdlDout), .sstrb(mdlStrobe)
  );

  int total = 0;
  int bad = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model, evaluated away from the active edge.
  logic [DW-1:0] mdlSample = '0;
  logic          stuck = 1'b0;
  logic          prevCs, prevS, started, finished, readEn, extMode, convPending, needFlushM;
  logic [7:0]    ctrlSh, gotCtrl;
  int            ctrlCnt, readCnt, rises, zeroRun, flushSeen, convTmr, protoErr;

  always @(negedge clk) begin
    if (!rstN) begin
      prevCs = 1'b1; prevS = 1'b0; mdlStrobe = 1'b1; mdlDout = 1'b0;
      started = 1'b0; finished = 1'b0; readEn = 1'b0; extMode = 1'b0;
      convPending = 1'b0; needFlushM = 1'b0; ctrlSh = '0; gotCtrl = '0;
      ctrlCnt = 0; readCnt = 0; rises = 0; zeroRun = 0; flushSeen = 0;
      convTmr = 0; protoErr = 0;
    end else begin
      if (csN && !prevCs) begin
        if (started && !finished) needFlushM = 1'b1;
        convPending = 1'b0;
        readEn = 1'b0;
      end
      if (!csN && prevCs) begin
        rises = 0; started = 1'b0; ctrlCnt = 0; readCnt = 0; zeroRun = 0;
        readEn = 1'b0; finished = 1'b0; flushSeen = 0; mdlDout = 1'b0;
      end
      if (!csN && sclk && !prevS) begin
        rises++;
        if (!started) begin
          if (mosi) begin
            started = 1'b1; ctrlSh = 8'h01; ctrlCnt = 1; flushSeen = zeroRun;
            if (needFlushM && zeroRun < 18) protoErr++;
            needFlushM = 1'b0;
          end else begin
            zeroRun++;
          end
        end else if (ctrlCnt < 8) begin
          ctrlSh = {ctrlSh[6:0], mosi};
          ctrlCnt++;
          if (ctrlCnt == 8) begin
            gotCtrl = ctrlSh;
            extMode = (ctrlSh[1:0] == 2'b11);
            if (extMode) readEn = 1'b1;
            else begin mdlStrobe = 1'b0; convPending = 1'b1; convTmr = 0; end
          end
        end else if (readEn && !finished) begin
          readCnt++;
          if (readCnt == 16) finished = 1'b1;
        end else begin
          protoErr++;
        end
      end
      if (!csN && !sclk && prevS && readEn && !finished) begin
        automatic int p = readCnt + 1;
        if (extMode) mdlDout = (p <= 14) ? mdlSample[14-p] : 1'b0;
        else         mdlDout = (p <= 2) ? 1'b0 : mdlSample[16-p];
      end
      if (convPending) begin
        convTmr++;
        if (convTmr >= CONV && !stuck) begin
          mdlStrobe = 1'b1; mdlDout = 1'b0; readEn = 1'b1; convPending = 1'b0;
        end
      end
      prevCs = csN; prevS = sclk;
    end
  end

  // Pin-level timing monitor for the serial clock and data line.
  int   runLen, timErr;
  logic prevLvl, prevMosi;
  always @(negedge clk) begin
    if (!rstN) begin
      runLen = 0; timErr = 0; prevLvl = 1'b0; prevMosi = 1'b0;
    end else begin
      if (sclk == prevLvl) runLen++;
      else begin
        if (prevLvl && runLen != HALF) timErr++;
        runLen = 1;
      end
      if (csN && sclk) timErr++;
      if (sclk && prevLvl && mosi !== prevMosi) timErr++;
      prevLvl = sclk; prevMosi = mosi;
    end
  end

  task automatic runTxn(input int ch, input int bip, input int se, input int im,
                        input logic [DW-1:0] smp, input int hold,
                        input int expRises, input int expFlush);
    logic [7:0]    expCtrl;
    logic [OW-1:0] expRes;
    logic [OW-1:0] held;
    int            guard, holdBad;
    expCtrl = {1'b1, 3'(ch), ~1'(bip), 1'(se), (im != 0) ? 2'b10 : 2'b11};
    expRes  = (bip != 0) ? {{(OW-DW){smp[DW-1]}}, smp} : {{(OW-DW){1'b0}}, smp};
    mdlSample = smp;
    @(negedge clk);
    reqChannel = 3'(ch); reqBipolar = 1'(bip); reqSingleEnded = 1'(se);
    reqIntClock = 1'(im); reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(convTimeout == 1'b0, "R8 flag clear after accept", int'(convTimeout), 0);
    guard = 0;
    while (!resValid && guard < 5000) begin @(negedge clk); guard++; end
    check(resValid == 1'b1, "R7 result arrives", int'(resValid), 1);
    held = resData; holdBad = 0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      if (!resValid || resData !== held || reqReady) holdBad++;
    end
    if (hold > 0) check(holdBad == 0, "R7 result held under backpressure", holdBad, 0);
    check(resData == expRes, (bip != 0) ? "R6 bipolar result" : "R5 unipolar result",
          int'(resData), int'(expRes));
    check(gotCtrl == expCtrl, "R2 command byte", int'(gotCtrl), int'(expCtrl));
    check(rises == expRises, (im != 0) ? "R4 clocks per window" : "R3 clocks per window",
          rises, expRises);
    check(flushSeen == expFlush, "R9 flush zeros", flushSeen, expFlush);
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R10 pins in reset",
          int'({csN, sclk, mosi}), 4);
    check(resValid == 1'b0 && convTimeout == 1'b0, "R10 outputs in reset",
          int'({resValid, convTimeout}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1 && csN == 1'b1, "R10 idle after reset", int'({reqReady, csN}), 3);

    // Full sweep of channel, polarity, input mode and clocking mode.
    for (int ch = 0; ch < 8; ch++)
      for (int bip = 0; bip < 2; bip++)
        for (int se = 0; se < 2; se++)
          for (int im = 0; im < 2; im++) begin
            automatic int idx = ((ch * 2 + bip) * 2 + se) * 2 + im;
            automatic logic [DW-1:0] smp;
            case (idx % 4)
              0: smp = 14'h2000;
              1: smp = 14'h1FFF;
              2: smp = 14'h3FFF ^ 14'(idx);
              default: smp = 14'(idx * 517 + 3);
            endcase
            runTxn(ch, bip, se, im, smp, (idx % 3) * 5, 24, 0);
          end

    // Corner samples in both polarities and modes.
    runTxn(0, 1, 1, 0, 14'h0000, 0, 24, 0);
    runTxn(5, 1, 0, 1, 14'h3FFF, 3, 24, 0);
    runTxn(7, 0, 1, 1, 14'h3FFF, 0, 24, 0);
    runTxn(2, 0, 0, 0, 14'h0001, 0, 24, 0);

    // Strobe never rises: expect the watchdog path.
    stuck = 1'b1;
    @(negedge clk);
    reqChannel = 3'd4; reqBipolar = 1'b0; reqSingleEnded = 1'b1;
    reqIntClock = 1'b1; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    repeat (1000) @(negedge clk);
    check(convTimeout == 1'b0 && csN == 1'b0 && sclk == 1'b0, "R4 parked while waiting",
          int'({convTimeout, csN, sclk}), 0);
    repeat (200) @(negedge clk);
    check(convTimeout == 1'b1, "R8 timeout flag", int'(convTimeout), 1);
    check(csN == 1'b1 && resValid == 1'b0, "R8 abort without result",
          int'({csN, resValid}), 2);
    stuck = 1'b0;

    runTxn(3, 1, 1, 0, 14'h2A55, 0, 42, 18);
    runTxn(6, 0, 0, 1, 14'h15AA, 0, 24, 0);

    check(protoErr == 0, "R4 converter protocol errors", protoErr, 0);
    check(timErr == 0, "R1 serial timing errors", timErr, 0);
    finishRun();
  end

endmodule